// File: doc/BRIEF.md
# Gray-Count Single-Slope Digitizer Back End

This block is the digital half of a many-channel single-slope converter. A single counter, shared by every channel, steps once per clock while an external ramp rises; its value is kept and distributed in Gray code, so a channel that samples it at any moment is off by at most one count. Each channel receives only a comparator flag. When that flag first rises during a conversion, the channel takes a copy of the running Gray count and keeps it until the next conversion starts. A channel whose flag never rises keeps the full-scale code.

Once a conversion is over, one load pulse moves every channel's held word into a per-channel shift stage. The stages are chained into one long serial path that ends at a single output pin. Each shift pulse moves the path by one bit. Channel 0's word leaves first, and each word leaves most significant bit first. The block also gives the running count as a binary value, found by XOR-prefix from the top bit, for checking.

Top module: `gray_ramp_digitizer`

## Requirements
- R1: After reset, busy, done, ser_out, count_gray and count_bin are all 0. Every channel holds 0, so a load with no conversion before it reads back all-zero words.
- R2: A conv_start seen at a clock edge sets count_bin to 0 and raises busy after that edge. The count then goes up by one at each later edge. Between two steps, exactly one bit of count_gray changes. count_gray always equals count_bin ^ (count_bin >> 1).
- R3: When count_bin reads 1023 (all ones) while busy is high, the next edge drops busy and raises done. The count then stays at 1023 until the next conv_start.
- R4: Each comparator input passes through a two-stage synchronizer. If a channel's input rises in the cycle in which count_bin reads m, the channel holds the Gray code of min(m+2, 1023).
- R5: Only the first rising edge of a channel's input in a conversion is taken. Later falls and rises in the same conversion leave the held word unchanged.
- R6: A channel with no accepted rising edge by the time the count reaches full scale holds the Gray code of 1023, which is 10'h200.
- R7: A load edge copies every channel's held word into its shift stage. Right after that edge, ser_out shows bit 9 of channel 0's word.
- R8: Each shift_en edge moves the chain by one bit, toward channel 0 and from bit 0 toward bit 9. The serial stream is channel 0 bits 9..0, then channel 1, and so on. The far end of the chain fills with zeros, so after 320 shifts a 32-channel frame is gone and ser_out reads 0. Load takes priority over shift.
- R9: With neither load nor shift_en high, ser_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| conv_start | input | 1 | Starts a conversion: clears the count and every channel |
| cmp_in | input | NCH | Comparator flags, one per channel, asynchronous |
| load | input | 1 | Copies the held words into the shift chain |
| shift_en | input | 1 | Moves the serial chain by one bit |
| count_gray | output | W | Shared running count, Gray coded |
| count_bin | output | W | Shared running count, binary |
| busy | output | 1 | A conversion is running |
| done | output | 1 | The last conversion reached full scale |
| ser_out | output | 1 | Serial data out, channel 0 first |

## Verification
The bench builds the block with its default values: 32 channels, a 10-bit count and two synchronizer stages. This makes every full-length conversion reachable, including the saturation step at count 1023 and a complete 320-bit frame drain. Channel flags rise at random counts, some past full scale. Directed channels cover a rise at count 0, rises at 1021 and 1022 that end up at the clamp, channels that never fire, and channels that toggle again after they fire.

// File: rtl/gray_ramp_digitizer.sv
module gray_ramp_digitizer #(
  parameter int NCH  = 32,
  parameter int W    = 10,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_start,
  input  logic [NCH-1:0] cmp_in,
  input  logic           load,
  input  logic           shift_en,
  output logic [W-1:0]   count_gray,
  output logic [W-1:0]   count_bin,
  output logic           busy,
  output logic           done,
  output logic           ser_out
);
  localparam logic [W-1:0] FULL = '1;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [W-1:0] b2g(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] gray_q;
  logic         run_q, fin_q;
  logic         at_full;

  assign count_bin  = g2b(gray_q);
  assign count_gray = gray_q;
  assign at_full    = (count_bin == FULL);
  assign busy       = run_q;
  assign done       = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else if (conv_start) begin
      gray_q <= '0;
      run_q  <= 1'b1;
      fin_q  <= 1'b0;
    end else if (run_q) begin
      if (at_full) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end else begin
        gray_q <= b2g(count_bin + 1'b1);
      end
    end
  end

  logic [NCH-1:0][W-1:0] lat_q;
  logic [NCH-1:0][W-1:0] sr_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SYNC-1:0] sync_q;
    logic            prev_q, got_q, rise, chain_in;

    assign rise = sync_q[SYNC-1] & ~prev_q;

    if (c == NCH - 1) begin : g_tail
      assign chain_in = 1'b0;
    end else begin : g_link
      assign chain_in = sr_q[c+1][W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], cmp_in[c]};
        prev_q <= sync_q[SYNC-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q[c] <= '0;
        got_q    <= 1'b0;
      end else if (conv_start) begin
        lat_q[c] <= '0;
        got_q    <= 1'b0;
      end else if (run_q && !got_q && (rise || at_full)) begin
        lat_q[c] <= gray_q;
        got_q    <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr_q[c] <= '0;
      else if (load)     sr_q[c] <= lat_q[c];
      else if (shift_en) sr_q[c] <= {sr_q[c][W-2:0], chain_in};
    end
  end

  assign ser_out = sr_q[0][W-1];
endmodule

module gray_ramp_digitizer_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_start,
  input logic         load,
  input logic         shift_en,
  input logic [W-1:0] count_gray,
  input logic [W-1:0] count_bin,
  input logic         busy,
  input logic         done,
  input logic         ser_out
);
  localparam logic [W-1:0] FULL = '1;

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r2_gray_matches_bin: assert property (@(posedge clk) disable iff (!rst_n)
    count_gray == (count_bin ^ (count_bin >> 1)));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (busy && !done && count_bin == '0));

  a_r2_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && count_bin != FULL) |=>
      ($countones(count_gray ^ $past(count_gray)) == 1));

  a_r3_end_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (count_bin == FULL));

  a_r3_hold_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !conv_start) |=> (done && $stable(count_gray)));

  a_r9_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(ser_out));
endmodule

bind gray_ramp_digitizer gray_ramp_digitizer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .load       (load),
  .shift_en   (shift_en),
  .count_gray (count_gray),
  .count_bin  (count_bin),
  .busy       (busy),
  .done       (done),
  .ser_out    (ser_out)
);

// File: tb/tb_gray_ramp_digitizer.sv
module tb_gray_ramp_digitizer;
  localparam int NCH  = 32;
  localparam int W    = 10;
  localparam int FULL = 1023;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           conv_start = 1'b0;
  logic [NCH-1:0] cmp_in = '0;
  logic           load = 1'b0;
  logic           shift_en = 1'b0;
  logic [W-1:0]   count_gray, count_bin;
  logic           busy, done, ser_out;

  always #4 clk = ~clk;

  gray_ramp_digitizer dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_in(cmp_in),
    .load(load), .shift_en(shift_en), .count_gray(count_gray),
    .count_bin(count_bin), .busy(busy), .done(done), .ser_out(ser_out)
  );

  int total = 0;
  int bad = 0;
  int rise_at [NCH];
  bit twitch [NCH];
  int expw [NCH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_gray(input int b);
    return b ^ (b >> 1);
  endfunction

  function automatic int from_gray(input int g);
    int b = 0;
    for (int i = W - 1; i >= 0; i--) b |= (((b >> (i + 1)) & 1) ^ ((g >> i) & 1)) << i;
    return b;
  endfunction

  function automatic int expect_code(input int m);
    if (m < 0) return FULL;
    return (m + 2 > FULL) ? FULL : m + 2;
  endfunction

  task automatic readout(input bit with_conv);
    logic [W-1:0] word [NCH];
    logic first;
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    first = ser_out;
    repeat (3) @(negedge clk);
    chk(ser_out == first, "R9", ser_out, first);
    chk(ser_out == ((to_gray(expw[0]) >> (W - 1)) & 1), "R7", ser_out,
        (to_gray(expw[0]) >> (W - 1)) & 1);
    for (int b = 0; b < NCH * W; b++) begin
      word[b / W] = {word[b / W][W-2:0], ser_out};
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
    chk(ser_out == 1'b0, "R8", ser_out, 0);
    for (int c = 0; c < NCH; c++) begin
      string req;
      if (!with_conv) req = "R1";
      else if (twitch[c]) req = "R5";
      else if (expw[c] == FULL) req = "R6";
      else req = "R4";
      chk(int'(word[c]) == to_gray(expw[c]), req, int'(word[c]), to_gray(expw[c]));
      chk(from_gray(int'(word[c])) == expw[c], "R8", from_gray(int'(word[c])), expw[c]);
    end
  endtask

  task automatic convert(input bit directed);
    for (int c = 0; c < NCH; c++) begin
      int r = int'($urandom_range(0, 1100));
      rise_at[c] = (r > FULL) ? -1 : r;
      twitch[c]  = ($urandom_range(0, 3) == 0);
    end
    if (directed) begin
      rise_at[0] = 0;    twitch[0] = 1'b0;
      rise_at[1] = 1;    twitch[1] = 1'b0;
      rise_at[2] = 1021; twitch[2] = 1'b0;
      rise_at[3] = 1022; twitch[3] = 1'b0;
      rise_at[4] = -1;   twitch[4] = 1'b0;
      rise_at[5] = 100;  twitch[5] = 1'b1;
      rise_at[6] = 0;    twitch[6] = 1'b1;
    end
    for (int c = 0; c < NCH; c++) expw[c] = expect_code(rise_at[c]);
    @(negedge clk) cmp_in = '0;
    repeat (4) @(negedge clk);
    conv_start = 1'b1;
    for (int k = 0; k <= FULL + 6; k++) begin
      @(negedge clk);
      conv_start = 1'b0;
      begin
        int ec = (k > FULL) ? FULL : k;
        chk(int'(count_bin) == ec, (k > FULL) ? "R3" : "R2", count_bin, ec);
        chk(int'(count_gray) == to_gray(ec), "R2", count_gray, to_gray(ec));
      end
      if (k == 0)    chk(busy == 1'b1, "R2", busy, 1);
      if (k == FULL) chk(done == 1'b0 && busy == 1'b1, "R3", done, 0);
      if (k == FULL + 1) chk(done == 1'b1 && busy == 1'b0, "R3", done, 1);
      for (int c = 0; c < NCH; c++) begin
        if (rise_at[c] >= 0) begin
          if (k == rise_at[c]) cmp_in[c] = 1'b1;
          if (twitch[c] && k == rise_at[c] + 5) cmp_in[c] = 1'b0;
          if (twitch[c] && k == rise_at[c] + 8) cmp_in[c] = 1'b1;
        end
      end
    end
    cmp_in = '0;
    readout(1'b1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20060519));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(done == 1'b0, "R1", done, 0);
    chk(count_bin == '0 && count_gray == '0, "R1", count_bin, 0);
    chk(ser_out == 1'b0, "R1", ser_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      expw[c] = 0;
      twitch[c] = 1'b0;
    end
    readout(1'b0);
    convert(1'b1);
    for (int n = 0; n < 4; n++) convert(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule